// File: doc/BRIEF.md
# Address Latch Strobe Quieting Unit

This unit drives the external address latch strobe pin of an 8-bit microcontroller core that is compatible with the 8051. The core supplies a raw strobe timing pulse on every machine cycle. While code runs from on-chip program memory, nothing outside the chip needs that strobe, and each edge of it adds electromagnetic noise. Software can therefore set a quiet bit in an auxiliary special-function register. While that bit is set, the pin stays low.

The quiet bit is not a plain output enable. When the core fetches code from external program space, or performs an external data move, the unit passes the strobe again for exactly as long as that activity lasts. When the activity ends, the strobe goes quiet again if the bit is still set. A strobe pulse is accepted or refused as a whole, at its rising edge, and the pin is registered so that it cannot glitch.

All ports are plain control pins with no handshake. The core presents its register write or read for a single cycle, and the strobe and access indications are sampled on every clock.

Top module: `ale_quiet_unit`

## Requirements
- R1: The auxiliary register answers at register address 0x8E. Bit 0 is the quiet control bit (1 = quiet). A write to 0x8E changes the quiet bit from the next clock onwards. A write to any other address leaves it unchanged.
- R2: A read of 0x8E returns bits 7..1 as 1 and bit 0 as the quiet bit, so the value is 0xFE or 0xFF. Writes to bits 7..1 have no effect. A read of any other address returns 0x00.
- R3: After reset, the quiet bit is 0 and the strobe pin is low.
- R4: While the quiet bit is 0, the strobe pin equals the raw strobe delayed by one clock.
- R5: While the quiet bit is 1 and neither access indication is high at a raw rising edge, that raw pulse never reaches the pin, and the pin stays low.
- R6: While the quiet bit is 1, a raw pulse whose rising edge comes with the external data move indication high is passed whole, one clock late.
- R7: While the quiet bit is 1 and the external fetch indication stays high, every raw pulse that rises during that time is passed.
- R8: After both access indications fall, raw pulses that rise later are suppressed again while the quiet bit is 1.
- R9: The pass decision is made only at the raw rising edge. A passed pulse lasts as long as the raw pulse even if the access ends part way through. A refused pulse stays low even if an access or a quiet-bit clear arrives part way through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | 8 | Special-function register address |
| sfr_wr_en | input | 1 | Register write strobe, one cycle |
| sfr_wdata | input | 8 | Register write data |
| sfr_rd_en | input | 1 | Register read strobe |
| sfr_rdata | output | 8 | Register read data (combinational) |
| ale_raw | input | 1 | Raw strobe timing pulse from the core |
| ext_fetch | input | 1 | High while code is fetched from external program space |
| ext_movx | input | 1 | High during an external data memory move |
| ale_pin | output | 1 | Registered strobe pin |

## Verification
Two events can land in the same clock: a write that flips the quiet bit, and a raw rising edge. The bench forces both together in directed steps and also lets them coincide at random. It expects the quiet value from before the write to govern that pulse. A second collision is an access indication rising or falling while a raw pulse is high. This is provoked in both directions, and the pin is checked to keep the whole-pulse decision made at the rising edge.

// File: rtl/ale_quiet_pkg.sv
package ale_quiet_pkg;
  // Conditions that can let a raw strobe pulse through
  typedef struct packed {
    logic quiet;
    logic fetch;
    logic movx;
  } pass_cond_t;
endpackage

// File: rtl/ale_aux_reg.sv
module ale_aux_reg #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] AUX_ADDR = 8'h8E,
  parameter int QUIET_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              quiet
);
  logic hit;
  logic [DATA_W-1:0] view;
  logic unused_wdata;

  assign hit = (addr == AUX_ADDR);
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) quiet <= 1'b0;
    else if (wr_en && hit) quiet <= wdata[QUIET_BIT];
  end

  // Only one bit is implemented; all other bits read as 1
  for (genvar b = 0; b < DATA_W; b++) begin : g_view
    if (b == QUIET_BIT) begin : g_impl
      assign view[b] = quiet;
    end else begin : g_fixed
      assign view[b] = 1'b1;
    end
  end

  assign rdata = (rd_en && hit) ? view : '0;
endmodule

// File: rtl/ale_pass_ctl.sv
module ale_pass_ctl
  import ale_quiet_pkg::*;
(
  input  pass_cond_t cond,
  output logic       allow
);
  // External activity overrides the quiet bit
  always_comb begin
    allow = 1'b1;
    if (cond.quiet && !cond.fetch && !cond.movx) allow = 1'b0;
  end
endmodule

// File: rtl/ale_pulse_shaper.sv
module ale_pulse_shaper (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic allow,
  output logic pin
);
  logic raw_q;
  logic rise;
  logic pin_nx;

  assign rise = raw && !raw_q;

  // Decide at the rising edge, then keep the choice for the pulse
  always_comb begin
    if (rise) pin_nx = allow;
    else      pin_nx = pin && raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      pin   <= 1'b0;
    end else begin
      raw_q <= raw;
      pin   <= pin_nx;
    end
  end
endmodule

// File: rtl/ale_quiet_unit.sv
module ale_quiet_unit
  import ale_quiet_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] AUX_ADDR = 8'h8E,
  parameter int QUIET_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr_en,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              sfr_rd_en,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic              ale_raw,
  input  logic              ext_fetch,
  input  logic              ext_movx,
  output logic              ale_pin
);
  logic       quiet_q;
  logic       allow;
  pass_cond_t cond;

  ale_aux_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .AUX_ADDR(AUX_ADDR), .QUIET_BIT(QUIET_BIT)
  ) u_aux (
    .clk(clk), .rst_n(rst_n), .addr(sfr_addr), .wr_en(sfr_wr_en),
    .wdata(sfr_wdata), .rd_en(sfr_rd_en), .rdata(sfr_rdata),
    .quiet(quiet_q)
  );

  assign cond = '{quiet: quiet_q, fetch: ext_fetch, movx: ext_movx};

  ale_pass_ctl u_pass (.cond(cond), .allow(allow));

  ale_pulse_shaper u_shape (
    .clk(clk), .rst_n(rst_n), .raw(ale_raw), .allow(allow), .pin(ale_pin)
  );
endmodule

// File: rtl/ale_quiet_chk.sv
module ale_quiet_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] sfr_addr,
  input logic       sfr_rd_en,
  input logic [7:0] sfr_rdata,
  input logic       ale_raw,
  input logic       ext_fetch,
  input logic       ext_movx,
  input logic       ale_pin,
  input logic       quiet_q
);
  // R2
  upper_bits_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd_en && sfr_addr == 8'h8E) |-> (sfr_rdata[7:1] == 7'h7F));

  // R3
  reset_loud_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!quiet_q && !ale_pin));

  // R4
  loud_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!quiet_q && ale_raw && !$past(ale_raw)) |=> ale_pin);

  // R5
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale_pin && quiet_q && !ext_fetch && !ext_movx) |=> !ale_pin);

  // R6
  movx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_movx && ale_raw && !$past(ale_raw)) |=> ale_pin);

  // R9
  whole_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_pin && ale_raw) |=> ale_pin);

  // R9
  pin_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale_pin |-> $past(ale_raw));
endmodule

bind ale_quiet_unit ale_quiet_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_rd_en(sfr_rd_en),
  .sfr_rdata(sfr_rdata), .ale_raw(ale_raw), .ext_fetch(ext_fetch),
  .ext_movx(ext_movx), .ale_pin(ale_pin), .quiet_q(quiet_q)
);

// File: tb/ale_quiet_unit_bench.sv
module ale_quiet_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = '0;
  logic       sfr_wr_en = 1'b0;
  logic [7:0] sfr_wdata = '0;
  logic       sfr_rd_en = 1'b0;
  logic [7:0] sfr_rdata;
  logic       ale_raw = 1'b0;
  logic       ext_fetch = 1'b0;
  logic       ext_movx = 1'b0;
  logic       ale_pin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  bit    m_quiet = 1'b0;
  bit    m_rawq  = 1'b0;
  bit    exp_pin = 1'b0;
  string exp_tag = "R3";

  always #2 clk = ~clk;

  ale_quiet_unit u_ale_quiet_unit (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr_en(sfr_wr_en),
    .sfr_wdata(sfr_wdata), .sfr_rd_en(sfr_rd_en), .sfr_rdata(sfr_rdata),
    .ale_raw(ale_raw), .ext_fetch(ext_fetch), .ext_movx(ext_movx),
    .ale_pin(ale_pin)
  );

  function automatic bit pass_ok(bit q, bit f, bit m);
    return !q || f || m;
  endfunction

  function automatic bit next_pin(bit raw, bit rawq, bit cur, bit ok);
    if (raw && !rawq) return ok;
    return cur && raw;
  endfunction

  function automatic logic [7:0] read_val(logic [7:0] a, bit q);
    return (a == 8'h8E) ? {7'h7F, q} : 8'h00;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // One clock: check pin, drive inputs, predict next pin
  task automatic step(bit raw, bit f, bit m, bit wr, logic [7:0] a,
                      logic [7:0] wd, bit rd);
    @(negedge clk);
    check(exp_tag, {7'b0, ale_pin}, {7'b0, exp_pin});
    ale_raw = raw; ext_fetch = f; ext_movx = m;
    sfr_wr_en = wr; sfr_addr = a; sfr_wdata = wd; sfr_rd_en = rd;
    if (!m_quiet) exp_tag = "R4";
    else if (raw && !m_rawq) exp_tag = f ? "R7" : (m ? "R6" : "R5");
    else if (exp_pin && raw) exp_tag = "R9";
    else exp_tag = "R8";
    exp_pin = next_pin(raw, m_rawq, exp_pin, pass_ok(m_quiet, f, m));
    m_rawq = raw;
    #1;
    if (rd) check(a == 8'h8E ? "R2" : "R2_other", sfr_rdata, read_val(a, m_quiet));
    if (wr && a == 8'h8E) m_quiet = wd[0];
  endtask

  task automatic wr_aux(logic [7:0] a, logic [7:0] d);
    step(1'b0, 1'b0, 1'b0, 1'b1, a, d, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h8E, 8'h00, 1'b1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3: reset state
    #1;
    check("R3", {7'b0, ale_pin}, 8'h00);
    sfr_addr = 8'h8E; sfr_rd_en = 1'b1; #0.5;
    check("R3", sfr_rdata, 8'hFE);
    sfr_rd_en = 1'b0;

    // R4: loud pulses
    for (int i = 0; i < 3; i++) begin
      step(1, 0, 0, 0, 8'h00, 8'h00, 0);
      step(1, 0, 0, 0, 8'h00, 8'h00, 0);
      step(0, 0, 0, 0, 8'h00, 8'h00, 0);
    end

    // R1: write to a neighbour address has no effect; R2 upper bits ignored
    wr_aux(8'h8F, 8'hFF);
    check("R1", sfr_rdata, 8'hFE);
    wr_aux(8'h8E, 8'h01);
    check("R1", sfr_rdata, 8'hFF);
    wr_aux(8'h8E, 8'hFE);
    check("R2", sfr_rdata, 8'hFE);
    wr_aux(8'h8E, 8'h01);

    // R5: quiet pulses
    for (int i = 0; i < 2; i++) begin
      step(1, 0, 0, 0, 8'h00, 8'h00, 0);
      step(0, 0, 0, 0, 8'h00, 8'h00, 0);
    end
    // R6: data move passes one pulse, then R8 quiet again
    step(1, 0, 1, 0, 8'h00, 8'h00, 0);
    step(1, 0, 0, 0, 8'h00, 8'h00, 0);   // R9 access ends mid-pulse
    step(0, 0, 0, 0, 8'h00, 8'h00, 0);
    step(1, 0, 0, 0, 8'h00, 8'h00, 0);
    step(0, 0, 0, 0, 8'h00, 8'h00, 0);
    // R7: external fetch over several pulses
    for (int i = 0; i < 3; i++) begin
      step(1, 1, 0, 0, 8'h00, 8'h00, 0);
      step(0, 1, 0, 0, 8'h00, 8'h00, 0);
    end
    // R9: refused pulse stays low though access starts mid-pulse
    step(1, 0, 0, 0, 8'h00, 8'h00, 0);
    step(1, 1, 1, 0, 8'h00, 8'h00, 0);
    step(0, 0, 0, 0, 8'h00, 8'h00, 0);
    // write clearing quiet in the same cycle as a raw rise: old value rules
    step(1, 0, 0, 1, 8'h8E, 8'h00, 0);
    step(1, 0, 0, 0, 8'h00, 8'h00, 0);
    step(0, 0, 0, 0, 8'h00, 8'h00, 0);
    // write setting quiet in the same cycle as a raw rise
    step(1, 0, 0, 1, 8'h8E, 8'h01, 0);
    step(0, 0, 0, 0, 8'h00, 8'h00, 0);
    step(1, 0, 0, 0, 8'h00, 8'h00, 0);
    step(0, 0, 0, 0, 8'h00, 8'h00, 0);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      bit rr, ff, mm, ww, rd;
      logic [7:0] aa;
      rr = ($urandom % 3) != 0;
      ff = ($urandom % 4) == 0;
      mm = ($urandom % 5) == 0;
      ww = ($urandom % 10) == 0;
      rd = ($urandom % 4) == 0;
      aa = (($urandom % 3) == 0) ? 8'($urandom) : 8'h8E;
      step(rr, ff, mm, ww, aa, 8'($urandom), rd);
    end
    step(0, 0, 0, 0, 8'h00, 8'h00, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule